// File: doc/BRIEF.md
# Delayed-Branch Pipelined Core

This block is a small pipelined processor core. It has a single memory port that serves both instruction fetch and data access. Every instruction is fetched in one cycle and executed in the next. Register-to-register arithmetic finishes there. LOAD and STORE add a third cycle in which the port carries the data transfer. While that transfer is on the port, no instruction is fetched.

A JUMP never flushes the pipeline. The instruction that sits in the word after the JUMP always completes, and only then is the target fetched. A compiler can therefore fill that slot with a NOOP or with useful work moved from before the branch. A HALT instruction freezes the core, so the surrounding environment can inspect memory. Register contents can be seen by storing them to memory before the HALT.

Top module: `dlb_core`

## Requirements
- R1: During reset and in the first cycle after it, the port presents address 0 with the write strobe low, and `halted` is low. All sixteen 16-bit registers start at zero.
- R2: Each instruction is 16 bits wide, with the opcode in bits [15:12]. The opcodes are: 0 NOOP; 1 LOAD, which writes register [11:8] from address [7:0]; 2 STORE, which writes register [11:8] to address [7:0]; 3 ADD, which computes reg[11:8] = reg[7:4] + reg[3:0]; 4 ADDI, which computes reg[11:8] += zero-extended [7:0]; 5 JUMP to address [7:0]; 15 HALT. The final memory state equals that of a one-at-a-time reference model that uses the same delayed-jump rule.
- R3: A result produced by ADD or ADDI is used by the very next instruction without any stall.
- R4: An instruction that reads the register loaded by the LOAD just before it waits one cycle, then uses the loaded value.
- R5: In the cycle after a LOAD or STORE executes, the port carries that instruction's data address. No fetch takes place in that cycle, and fetch resumes in the cycle after.
- R6: The word after a JUMP is fetched in the cycle after the JUMP and is executed. The jump target is fetched in the cycle after that.
- R7: If the port is busy with a data transfer while a JUMP executes, the delay-slot word is still fetched before the target.
- R8: A program whose JUMP slot holds a NOOP and a reordered program whose slot holds the moved ADDI (with the target advanced by one) leave the same result in memory.
- R9: After HALT executes, the core does not execute the words that follow it and does not write memory again. `halted` stays high and the port address stays constant.
- R10: If a LOAD's result and a younger ADD's result target the same register in the same cycle, the ADD's value is kept.
- R11: A STORE raises the write strobe for one cycle, driving the register value onto `mem_wdata` at the store address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Shared address for fetch or data access |
| mem_we | output | 1 | Write strobe for STORE data |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data from memory, valid in the same cycle |
| halted | output | 1 | High once HALT has executed |

## Verification
The hardest case to reach from the ports is a JUMP that executes in the same cycle as an earlier LOAD's data access. In that case the delay-slot fetch must wait one cycle while the jump target is held. The stimulus places a LOAD immediately before a JUMP and makes the slot instruction depend on the loaded register. It then samples the port address cycle by cycle: fetch, fetch, data address, slot, target. Separate programs set up a same-cycle write collision between a LOAD and an ADD, and a HALT followed by STOREs that must never run.

// File: rtl/dlb_pkg.sv
package dlb_pkg;
    localparam int DW   = 16;
    localparam int AW   = 8;
    localparam int RW   = 4;
    localparam int OPW  = 4;
    localparam int IW   = OPW + RW + AW;
    localparam int NREG = 1 << RW;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_ADDI  = 4'd4,
        OP_JUMP  = 4'd5,
        OP_HALT  = 4'd15
    } op_e;

    typedef struct packed {
        logic          ld;
        logic          st;
        logic          add;
        logic          addi;
        logic          jmp;
        logic          hlt;
        logic          use_a;
        logic          use_b;
        logic [RW-1:0] rd;
        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
        logic [AW-1:0] fld;
    } dec_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [IW-1:0] ir;
        logic          ir_v;
        logic          d_v;
        logic          d_ld;
        logic [RW-1:0] d_rd;
        logic [AW-1:0] d_addr;
        logic [DW-1:0] d_data;
        logic          jp;
        logic [AW-1:0] jt;
        logic          halt;
    } core_st_t;
endpackage

// File: rtl/dlb_decode.sv
module dlb_decode
    import dlb_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    logic [OPW-1:0] op;

    always_comb begin
        op      = instr[IW-1 -: OPW];
        dec     = '0;
        dec.rd  = instr[AW +: RW];
        dec.fld = instr[AW-1:0];
        case (op)
            OP_LOAD:  dec.ld = 1'b1;
            OP_STORE: begin
                dec.st    = 1'b1;
                dec.ra    = instr[AW +: RW];
                dec.use_a = 1'b1;
            end
            OP_ADD: begin
                dec.add   = 1'b1;
                dec.ra    = instr[RW +: RW];
                dec.rb    = instr[RW-1:0];
                dec.use_a = 1'b1;
                dec.use_b = 1'b1;
            end
            OP_ADDI: begin
                dec.addi  = 1'b1;
                dec.ra    = instr[AW +: RW];
                dec.use_a = 1'b1;
            end
            OP_JUMP:  dec.jmp = 1'b1;
            OP_HALT:  dec.hlt = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/dlb_regfile.sv
module dlb_regfile
    import dlb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra_a,
    input  logic [RW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we_e,
    input  logic [RW-1:0] wa_e,
    input  logic [DW-1:0] wd_e,
    input  logic          we_d,
    input  logic [RW-1:0] wa_d,
    input  logic [DW-1:0] wd_d
);
    logic [DW-1:0] rf_q [NREG];

    assign rd_a = rf_q[ra_a];
    assign rd_b = rf_q[ra_b];

    // The execute-phase port is written last so the younger instruction wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            if (we_d) rf_q[wa_d] <= wd_d;
            if (we_e) rf_q[wa_e] <= wd_e;
        end
    end
endmodule

// File: rtl/dlb_core.sv
module dlb_core
    import dlb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);
    core_st_t      st_q, st_d;
    dec_t          dec;
    logic [DW-1:0] rdat_a, rdat_b, alu_res;
    logic          e_go, ld_stall, fetch, d_busy, e_jump, we_e, we_d;
    logic [AW-1:0] e_tgt;
    logic [IW-1:0] ir_q;

    dlb_decode u_dec (
        .instr (st_q.ir),
        .dec   (dec)
    );

    dlb_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (dec.ra),
        .ra_b  (dec.rb),
        .rd_a  (rdat_a),
        .rd_b  (rdat_b),
        .we_e  (we_e),
        .wa_e  (dec.rd),
        .wd_e  (alu_res),
        .we_d  (we_d),
        .wa_d  (st_q.d_rd),
        .wd_d  (mem_rdata)
    );

    always_comb begin
        d_busy   = st_q.d_v;
        ld_stall = st_q.ir_v && st_q.d_v && st_q.d_ld &&
                   ((dec.use_a && dec.ra == st_q.d_rd) ||
                    (dec.use_b && dec.rb == st_q.d_rd));
        e_go     = st_q.ir_v && !ld_stall;
        e_jump   = e_go && dec.jmp;
        e_tgt    = dec.fld;
        fetch    = !st_q.halt && !st_q.d_v && !(e_go && dec.hlt);
        alu_res  = dec.add ? rdat_a + rdat_b
                           : rdat_a + {{(DW-AW){1'b0}}, dec.fld};
        we_e     = e_go && (dec.add || dec.addi);
        we_d     = st_q.d_v && st_q.d_ld;
        ir_q     = st_q.ir;

        mem_addr  = st_q.d_v ? st_q.d_addr : st_q.pc;
        mem_we    = st_q.d_v && !st_q.d_ld;
        mem_wdata = st_q.d_data;
        halted    = st_q.halt;

        st_d        = st_q;
        st_d.d_v    = e_go && (dec.ld || dec.st);
        st_d.d_ld   = dec.ld;
        st_d.d_rd   = dec.rd;
        st_d.d_addr = dec.fld;
        st_d.d_data = rdat_a;

        if (fetch) begin
            st_d.ir   = mem_rdata[IW-1:0];
            st_d.ir_v = 1'b1;
            st_d.pc   = st_q.pc + 1'b1;
        end else if (!ld_stall) begin
            st_d.ir_v = 1'b0;
        end

        if (e_jump) begin
            if (fetch) begin
                st_d.pc = dec.fld;
            end else begin
                st_d.jp = 1'b1;
                st_d.jt = dec.fld;
            end
        end

        if (st_q.jp && fetch) begin
            st_d.pc = st_q.jt;
            st_d.jp = 1'b0;
        end

        if (e_go && dec.hlt) st_d.halt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dlb_core_chk.sv
module dlb_core_chk
    import dlb_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          halted,
    input logic          e_jump,
    input logic [AW-1:0] e_tgt,
    input logic          d_busy,
    input logic          ld_stall,
    input logic [IW-1:0] ir_q
);
    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_addr == '0 && !mem_we)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |=> $stable(ir_q)); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (e_jump && !d_busy && !halted) |=> (mem_addr == $past(e_tgt))); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we); // R9

    AST_HALT_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr)); // R9
endmodule

bind dlb_core dlb_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted),
    .e_jump   (e_jump),
    .e_tgt    (e_tgt),
    .d_busy   (d_busy),
    .ld_stall (ld_stall),
    .ir_q     (ir_q)
);

// File: tb/sim_dlb_core.sv
module sim_dlb_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];
    logic [15:0] ref_rf  [16];
    int checks = 0;
    int fails = 0;
    int we_after_halt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] = mem_wdata;
    always @(negedge clk) if (rst_n && halted && mem_we) we_after_halt++;

    dlb_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] a,
                                        input logic [7:0] f);
        return {op, a, f};
    endfunction

    function automatic logic [15:0] i_add(input logic [3:0] d, input logic [3:0] s1,
                                          input logic [3:0] s2);
        return {4'd3, d, s1, s2};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    endtask

    // Sequential reference: one instruction at a time, jump lands after the slot.
    task automatic run_model();
        logic [7:0] pc, npc;
        logic [15:0] ins;
        for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
        for (int i = 0; i < 16; i++) ref_rf[i] = 16'h0;
        pc = 8'd0;
        npc = 8'd1;
        for (int step = 0; step < 2000; step++) begin
            ins = ref_mem[pc];
            pc = npc;
            npc = npc + 8'd1;
            case (ins[15:12])
                4'd1: ref_rf[ins[11:8]] = ref_mem[ins[7:0]];
                4'd2: ref_mem[ins[7:0]] = ref_rf[ins[11:8]];
                4'd3: ref_rf[ins[11:8]] = ref_rf[ins[7:4]] + ref_rf[ins[3:0]];
                4'd4: ref_rf[ins[11:8]] = ref_rf[ins[11:8]] + {8'h0, ins[7:0]};
                4'd5: npc = ins[7:0];
                default: ;
            endcase
            if (ins[15:12] == 4'd15) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wait_halt(input string tag);
        for (int c = 0; c < 600 && !halted; c++) @(negedge clk);
        chk({tag, " halt reached"}, {15'h0, halted}, 16'h1);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_model(input string tag);
        int bad = 0;
        for (int a = 128; a < 256; a++)
            if (mem[a] !== ref_mem[a]) begin
                bad++;
                $display("  mismatch %s @%h dut=%h ref=%h", tag, a[7:0], mem[a], ref_mem[a]);
            end
        chk({tag, " data region vs model"}, bad[15:0], 16'h0);
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = enc(4'd15, 4'd0, 8'd0);
        do_reset();
        chk("R1 first address", {8'h0, mem_addr}, 16'h0000);
        chk("R1 write strobe", {15'h0, mem_we}, 16'h0);
        chk("R1 halted low", {15'h0, halted}, 16'h0);
        wait_halt("R1");
    endtask

    task automatic t_alu();
        clear_mem();
        mem[0] = enc(4'd4, 4'd1, 8'd3);
        mem[1] = enc(4'd4, 4'd2, 8'd4);
        mem[2] = i_add(4'd3, 4'd1, 4'd2);
        mem[3] = i_add(4'd4, 4'd3, 4'd3);
        mem[4] = i_add(4'd5, 4'd4, 4'd1);
        mem[5] = enc(4'd4, 4'd5, 8'hFF);
        mem[6] = enc(4'd2, 4'd3, 8'h80);
        mem[7] = enc(4'd2, 4'd4, 8'h81);
        mem[8] = enc(4'd2, 4'd5, 8'h82);
        mem[9] = enc(4'd15, 4'd0, 8'd0);
        run_model();
        do_reset();
        wait_halt("R3");
        chk("R3 back-to-back ADD", mem[8'h81], 16'd14);
        chk("R3 ADDI chain", mem[8'h82], 16'd272);
        chk("R11 stored value", mem[8'h80], 16'd7);
        cmp_model("R2 alu program");
    endtask

    task automatic t_load();
        clear_mem();
        mem[8'hA0] = 16'h1234;
        mem[8'hA1] = 16'h0011;
        mem[0] = enc(4'd1, 4'd1, 8'hA0);
        mem[1] = i_add(4'd2, 4'd1, 4'd1);
        mem[2] = enc(4'd1, 4'd3, 8'hA1);
        mem[3] = i_add(4'd3, 4'd2, 4'd2);
        mem[4] = enc(4'd2, 4'd1, 8'h83);
        mem[5] = enc(4'd2, 4'd2, 8'h84);
        mem[6] = enc(4'd2, 4'd3, 8'h85);
        mem[7] = enc(4'd15, 4'd0, 8'd0);
        run_model();
        do_reset();
        wait_halt("R4");
        chk("R4 load-use value", mem[8'h84], 16'h2468);
        chk("R10 younger ADD wins", mem[8'h85], 16'h48D0);
        cmp_model("R2 load program");
    endtask

    task automatic t_port();
        clear_mem();
        mem[0] = enc(4'd1, 4'd1, 8'h80);
        mem[1] = enc(4'd0, 4'd0, 8'd0);
        mem[2] = enc(4'd2, 4'd1, 8'h88);
        mem[3] = enc(4'd15, 4'd0, 8'd0);
        mem[8'h80] = 16'hBEEF;
        do_reset();
        chk("R5 c0 fetch", {8'h0, mem_addr}, 16'h0000);
        @(negedge clk); #1;
        chk("R5 c1 fetch", {8'h0, mem_addr}, 16'h0001);
        @(negedge clk); #1;
        chk("R5 c2 data address", {8'h0, mem_addr}, 16'h0080);
        chk("R5 c2 read only", {15'h0, mem_we}, 16'h0);
        @(negedge clk); #1;
        chk("R5 c3 fetch resumes", {8'h0, mem_addr}, 16'h0002);
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk("R11 store strobe", {15'h0, mem_we}, 16'h1);
        chk("R11 store address", {8'h0, mem_addr}, 16'h0088);
        chk("R11 store data", mem_wdata, 16'hBEEF);
        @(negedge clk); #1;
        chk("R11 strobe one cycle", {15'h0, mem_we}, 16'h0);
        wait_halt("R5");
    endtask

    task automatic t_slot();
        clear_mem();
        mem[0] = enc(4'd5, 4'd0, 8'h20);
        mem[1] = enc(4'd4, 4'd2, 8'd5);
        mem[2] = enc(4'd4, 4'd2, 8'd9);
        mem[8'h20] = enc(4'd2, 4'd2, 8'h90);
        mem[8'h21] = enc(4'd15, 4'd0, 8'd0);
        do_reset();
        chk("R6 jump fetched", {8'h0, mem_addr}, 16'h0000);
        @(negedge clk); #1;
        chk("R6 slot fetched", {8'h0, mem_addr}, 16'h0001);
        @(negedge clk); #1;
        chk("R6 target fetched", {8'h0, mem_addr}, 16'h0020);
        wait_halt("R6");
        chk("R6 slot executed", mem[8'h90], 16'd5);
    endtask

    task automatic t_slot_busy();
        clear_mem();
        mem[8'h80] = 16'h0007;
        mem[0] = enc(4'd1, 4'd3, 8'h80);
        mem[1] = enc(4'd5, 4'd0, 8'h30);
        mem[2] = enc(4'd4, 4'd3, 8'd1);
        mem[3] = enc(4'd4, 4'd3, 8'h40);
        mem[8'h30] = enc(4'd2, 4'd3, 8'h91);
        mem[8'h31] = enc(4'd15, 4'd0, 8'd0);
        do_reset();
        @(negedge clk); #1;
        chk("R7 jump fetched", {8'h0, mem_addr}, 16'h0001);
        @(negedge clk); #1;
        chk("R7 data access", {8'h0, mem_addr}, 16'h0080);
        @(negedge clk); #1;
        chk("R7 slot before target", {8'h0, mem_addr}, 16'h0002);
        @(negedge clk); #1;
        chk("R7 target after slot", {8'h0, mem_addr}, 16'h0030);
        wait_halt("R7");
        chk("R7 slot used loaded value", mem[8'h91], 16'd8);
    endtask

    task automatic t_reorder();
        logic [15:0] res_a;
        clear_mem();
        mem[8'hA0] = 16'h1234;
        mem[0] = enc(4'd1, 4'd1, 8'hA0);
        mem[1] = enc(4'd4, 4'd1, 8'd1);
        mem[2] = enc(4'd5, 4'd0, 8'd6);
        mem[3] = enc(4'd0, 4'd0, 8'd0);
        mem[4] = i_add(4'd1, 4'd1, 4'd2);
        mem[5] = i_add(4'd3, 4'd2, 4'd2);
        mem[6] = enc(4'd2, 4'd1, 8'h86);
        mem[7] = enc(4'd15, 4'd0, 8'd0);
        run_model();
        do_reset();
        wait_halt("R8");
        res_a = mem[8'h86];
        chk("R8 NOOP slot result", res_a, 16'h1235);
        cmp_model("R8 NOOP-slot program");
        clear_mem();
        mem[8'hA0] = 16'h1234;
        mem[0] = enc(4'd1, 4'd1, 8'hA0);
        mem[1] = enc(4'd5, 4'd0, 8'd5);
        mem[2] = enc(4'd4, 4'd1, 8'd1);
        mem[3] = i_add(4'd1, 4'd1, 4'd2);
        mem[4] = i_add(4'd3, 4'd2, 4'd2);
        mem[5] = enc(4'd2, 4'd1, 8'h86);
        mem[6] = enc(4'd15, 4'd0, 8'd0);
        run_model();
        do_reset();
        wait_halt("R8");
        chk("R8 reordered equals NOOP version", mem[8'h86], res_a);
        cmp_model("R8 reordered program");
    endtask

    task automatic t_halt();
        logic [7:0] addr_at_halt;
        clear_mem();
        mem[8'h92] = 16'hDEAD;
        mem[8'h93] = 16'hDEAD;
        mem[0] = enc(4'd4, 4'd1, 8'd7);
        mem[1] = enc(4'd15, 4'd0, 8'd0);
        mem[2] = enc(4'd2, 4'd1, 8'h92);
        mem[3] = enc(4'd2, 4'd1, 8'h93);
        we_after_halt = 0;
        do_reset();
        wait_halt("R9");
        addr_at_halt = mem_addr;
        repeat (6) @(negedge clk);
        chk("R9 halted stays high", {15'h0, halted}, 16'h1);
        chk("R9 address frozen", {8'h0, mem_addr}, {8'h0, addr_at_halt});
        chk("R9 word after halt skipped", mem[8'h92], 16'hDEAD);
        chk("R9 later word skipped", mem[8'h93], 16'hDEAD);
        chk("R9 no write while halted", we_after_halt[15:0], 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_load();
        t_port();
        t_slot();
        t_slot_busy();
        t_reorder();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule